// File: doc/BRIEF.md
# Windowed Indirect Register Bridge

This block is an APB slave that gives a host access to a wide 16-bit internal register space through a narrow window. Each channel exposes three host registers: a pointer that holds the target internal address, a data port, and a control word. A host access to the data port becomes a request on that channel's internal register port, at the address in the pointer. Two channels sit side by side at different window offsets. Each drives its own internal port and keeps its own state.

Internal reads are pipelined. A data-port read returns the result of the previous fetch at once and starts a new fetch. Software therefore reads the data port twice and keeps the second value. A data-port write is a single host access, and the host waits until the internal write has finished. Software writes the pointer twice before each data access. Writing the same value again changes nothing.

An internal access fails when the port answers with an error or gives no answer within a bounded number of cycles. Bit 15 of the control word selects whether a failure is reported to the host as an APB slave error.

Top module: `regwin_bridge`

## Requirements
- R1: Channel n decodes host byte offsets n*0x10 + 0x0 (pointer), + 0x4 (data port) and + 0x8 (control). Address bits [1:0] are ignored. Channel 0 is at 0x00 to 0x08 and channel 1 is at 0x10 to 0x18.
- R2: A pointer write keeps only wdata[15:0]. A pointer read returns that value, zero-extended to 32 bits. Writing the same pointer value again starts no internal request and leaves the read-back unchanged.
- R3: A data-port read completes without wait states. It returns the channel's holding register and starts an internal read (ireq=1, iwe=0) at the pointer address. When that read is acknowledged, irdata is loaded into the holding register, so the next data-port read returns it.
- R4: A data-port read that arrives while the channel's previous fetch is still outstanding is held (pready=0) until that fetch ends. It then returns the fetched value.
- R5: A single data-port write raises ireq with iwe=1, iaddr equal to the pointer and iwdata equal to the written word. pready stays low until the internal port acknowledges, reports an error or times out. The host write completes in the cycle after that.
- R6: ireq stays high, with iaddr stable, until iack or ierr is sampled high or the request times out. It is low in the cycle after iack or ierr.
- R7: A request that gets neither iack nor ierr is withdrawn after exactly TMO (default 16) cycles with ireq high, and counts as a failed access.
- R8: The control word is a 32-bit register that can be read and written. When its bit 15 is 1, a failed write is reported with pslverr=1 when it completes. A failed fetch is reported with pslverr=1 on the data-port read that returns it. When bit 15 is 0, pslverr stays 0.
- R9: A failed fetch loads zero into the holding register.
- R10: Each channel has its own pointer, holding register and internal port. Accesses to one channel never change the values that the other channel returns.
- R11: Offset 0xC inside a channel, and any offset whose channel index is NCH or more, reads as zero with no wait state and no error. Writes there have no effect.
- R12: After reset, the pointer, control word and holding register read zero, and no internal request is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when 1 |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | DATA_W | APB write data |
| prdata | output | DATA_W | APB read data |
| pready | output | 1 | APB ready; low holds the transfer |
| pslverr | output | 1 | APB slave error |
| ireq | output | NCH | Internal request, one bit per channel |
| iwe | output | NCH | Internal write enable, one bit per channel |
| iaddr | output | NCH*IADDR_W | Internal address, one field per channel |
| iwdata | output | NCH*DATA_W | Internal write data, one field per channel |
| iack | input | NCH | Internal acknowledge, one bit per channel |
| ierr | input | NCH | Internal error completion, one bit per channel |
| irdata | input | NCH*DATA_W | Internal read data, valid with iack |

## Verification
The properties assume an APB host that holds paddr, pwrite and pwdata stable from setup until pready is sampled high. They also assume that each internal port answers only while its ireq is high, with iack or ierr lasting a single cycle. The bench's transfer task holds every APB signal for the whole transfer. Its responder pulses iack or ierr for one cycle after a latency set per channel, and it can also be told to stay silent so the timeout is exercised.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
  typedef enum logic [1:0] {
    REG_PTR  = 2'd0,
    REG_PORT = 2'd1,
    REG_CTL  = 2'd2,
    REG_NONE = 2'd3
  } regsel_e;

  typedef enum logic [1:0] {
    CH_IDLE  = 2'd0,
    CH_FETCH = 2'd1,
    CH_WRITE = 2'd2,
    CH_WDONE = 2'd3
  } chst_e;

  localparam int ERR_EN_BIT = 15;
endpackage

// File: rtl/regwin_decode.sv
module regwin_decode
  import regwin_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NCH    = 2
) (
  input  logic [ADDR_W-1:0] paddr,
  output logic [NCH-1:0]    hit,
  output regsel_e           sel
);
  localparam int IDX_W = ADDR_W - 4;

  assign sel = regsel_e'(paddr[3:2]);

  for (genvar g = 0; g < NCH; g++) begin : g_hit
    assign hit[g] = (paddr[ADDR_W-1:4] == IDX_W'(g));
  end
endmodule

// File: rtl/regwin_chan.sv
module regwin_chan
  import regwin_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int IADDR_W = 16,
  parameter int TMO     = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               acc,
  input  logic               wr,
  input  regsel_e            sel,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  output logic               ready,
  output logic               slverr,
  output logic               ireq,
  output logic               iwe,
  output logic [IADDR_W-1:0] iaddr,
  output logic [DATA_W-1:0]  iwdata,
  input  logic               iack,
  input  logic               ierr,
  input  logic [DATA_W-1:0]  irdata
);
  localparam int CNT_W = $clog2(TMO);

  chst_e              st;
  logic [IADDR_W-1:0] ptr;
  logic [DATA_W-1:0]  ctl;
  logic [DATA_W-1:0]  hold;
  logic               hold_bad;
  logic               wr_bad;
  logic [CNT_W-1:0]   cnt;
  logic               finish;
  logic               good;
  logic               idle;
  logic               err_en;

  assign idle   = (st == CH_IDLE);
  assign err_en = ctl[ERR_EN_BIT];
  assign good   = iack & ~ierr;
  assign finish = iack | ierr | (cnt == CNT_W'(TMO - 1));

  always_comb begin
    rdata  = '0;
    ready  = 1'b1;
    slverr = 1'b0;
    if (acc) begin
      unique case (sel)
        REG_PTR: begin
          if (wr) ready = idle;
          else    rdata = DATA_W'(ptr);
        end
        REG_PORT: begin
          if (wr) begin
            ready  = (st == CH_WDONE);
            slverr = ready & err_en & wr_bad;
          end else begin
            ready  = idle;
            rdata  = idle ? hold : '0;
            slverr = idle & err_en & hold_bad;
          end
        end
        REG_CTL: if (!wr) rdata = ctl;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= CH_IDLE;
      ptr      <= '0;
      ctl      <= '0;
      hold     <= '0;
      hold_bad <= 1'b0;
      wr_bad   <= 1'b0;
      cnt      <= '0;
      iwdata   <= '0;
    end else begin
      if (acc && wr && sel == REG_CTL) ctl <= wdata;
      unique case (st)
        CH_IDLE: begin
          cnt <= '0;
          if (acc && wr && sel == REG_PTR) ptr <= wdata[IADDR_W-1:0];
          if (acc && sel == REG_PORT) begin
            if (wr) begin
              iwdata <= wdata;
              st     <= CH_WRITE;
            end else begin
              st <= CH_FETCH;
            end
          end
        end
        CH_FETCH: begin
          if (finish) begin
            hold     <= good ? irdata : '0;
            hold_bad <= ~good;
            st       <= CH_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        CH_WRITE: begin
          if (finish) begin
            wr_bad <= ~good;
            st     <= CH_WDONE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= CH_IDLE;
      endcase
    end
  end

  assign ireq  = (st == CH_FETCH) || (st == CH_WRITE);
  assign iwe   = (st == CH_WRITE);
  assign iaddr = ptr;
endmodule

// File: rtl/regwin_bridge.sv
module regwin_bridge
  import regwin_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int IADDR_W = 16,
  parameter int NCH     = 2,
  parameter int TMO     = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   psel,
  input  logic                   penable,
  input  logic                   pwrite,
  input  logic [ADDR_W-1:0]      paddr,
  input  logic [DATA_W-1:0]      pwdata,
  output logic [DATA_W-1:0]      prdata,
  output logic                   pready,
  output logic                   pslverr,
  output logic [NCH-1:0]         ireq,
  output logic [NCH-1:0]         iwe,
  output logic [NCH*IADDR_W-1:0] iaddr,
  output logic [NCH*DATA_W-1:0]  iwdata,
  input  logic [NCH-1:0]         iack,
  input  logic [NCH-1:0]         ierr,
  input  logic [NCH*DATA_W-1:0]  irdata
);
  logic [NCH-1:0]             hit;
  regsel_e                    sel;
  logic [NCH-1:0][DATA_W-1:0] ch_rd;
  logic [NCH-1:0]             ch_rdy;
  logic [NCH-1:0]             ch_err;

  regwin_decode #(.ADDR_W(ADDR_W), .NCH(NCH)) u_dec (
    .paddr(paddr), .hit(hit), .sel(sel)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    regwin_chan #(.DATA_W(DATA_W), .IADDR_W(IADDR_W), .TMO(TMO)) u_ch (
      .clk    (clk),
      .rst    (rst),
      .acc    (psel & penable & hit[g]),
      .wr     (pwrite),
      .sel    (sel),
      .wdata  (pwdata),
      .rdata  (ch_rd[g]),
      .ready  (ch_rdy[g]),
      .slverr (ch_err[g]),
      .ireq   (ireq[g]),
      .iwe    (iwe[g]),
      .iaddr  (iaddr[g*IADDR_W +: IADDR_W]),
      .iwdata (iwdata[g*DATA_W +: DATA_W]),
      .iack   (iack[g]),
      .ierr   (ierr[g]),
      .irdata (irdata[g*DATA_W +: DATA_W])
    );
  end

  always_comb begin
    prdata = '0;
    for (int i = 0; i < NCH; i++) prdata = prdata | ch_rd[i];
  end

  assign pready  = &ch_rdy;
  assign pslverr = |ch_err;
endmodule

// File: rtl/regwin_bridge_chk.sv
module regwin_bridge_chk #(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int IADDR_W = 16,
  parameter int NCH     = 2,
  parameter int TMO     = 16
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   psel,
  input logic                   penable,
  input logic                   pwrite,
  input logic [ADDR_W-1:0]      paddr,
  input logic [DATA_W-1:0]      prdata,
  input logic                   pready,
  input logic                   pslverr,
  input logic [NCH-1:0]         ireq,
  input logic [NCH-1:0]         iwe,
  input logic [NCH*IADDR_W-1:0] iaddr,
  input logic [NCH-1:0]         iack,
  input logic [NCH-1:0]         ierr
);
  localparam int RUN_W = $clog2(TMO + 2) + 1;
  localparam int IDX_W = ADDR_W - 4;

  logic undec;
  assign undec = (paddr[3:2] == 2'd3) || (int'(paddr[ADDR_W-1:4]) >= NCH);

  assert_err_ready_R8: assert property (@(posedge clk) disable iff (rst)
    pslverr |-> pready);

  assert_undec_R11: assert property (@(posedge clk) disable iff (rst)
    (psel && penable && undec) |-> (pready && prdata == '0 && !pslverr));

  for (genvar g = 0; g < NCH; g++) begin : g_c
    logic [RUN_W-1:0] run;
    always_ff @(posedge clk) begin
      if (rst)          run <= '0;
      else if (ireq[g]) run <= run + 1'b1;
      else              run <= '0;
    end

    assert_req_bounded_R7: assert property (@(posedge clk) disable iff (rst)
      ireq[g] |-> (run < RUN_W'(TMO)));

    assert_req_drop_R6: assert property (@(posedge clk) disable iff (rst)
      (ireq[g] && (iack[g] || ierr[g])) |=> !ireq[g]);

    assert_addr_stable_R6: assert property (@(posedge clk) disable iff (rst)
      (ireq[g] && $past(ireq[g]) && !$past(iack[g] || ierr[g]))
        |-> $stable(iaddr[g*IADDR_W +: IADDR_W]));

    assert_wr_hold_R5: assert property (@(posedge clk) disable iff (rst)
      (psel && penable && pwrite && paddr[ADDR_W-1:4] == IDX_W'(g) &&
       paddr[3:2] == 2'd1 && ireq[g] && iwe[g] && !iack[g] && !ierr[g])
        |-> !pready);
  end
endmodule

bind regwin_bridge regwin_bridge_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IADDR_W(IADDR_W), .NCH(NCH), .TMO(TMO)
) u_chk (
  .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .prdata(prdata), .pready(pready), .pslverr(pslverr),
  .ireq(ireq), .iwe(iwe), .iaddr(iaddr), .iack(iack), .ierr(ierr)
);

// File: tb/regwin_bridge_tb.sv
module regwin_bridge_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr;
  logic [1:0]  ireq, iwe;
  logic [31:0] iaddr;
  logic [63:0] iwdata;
  logic [1:0]  iack = '0, ierr = '0;
  logic [63:0] irdata;

  int checks = 0, errors = 0;
  int lat[2], mode[2], rcnt[2];
  int rises[2], cur[2], req_len[2];
  logic prev[2];
  logic [15:0] last_wa[2];
  logic [31:0] last_wd[2];
  logic        last_we[2];

  always #2.5 clk = ~clk;

  regwin_bridge u_dut (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .ireq(ireq), .iwe(iwe), .iaddr(iaddr),
    .iwdata(iwdata), .iack(iack), .ierr(ierr), .irdata(irdata)
  );

  assign irdata[31:0]  = {16'hA05A, iaddr[15:0]};
  assign irdata[63:32] = {16'hA15A, iaddr[31:16]};

  function automatic logic [31:0] fval(int c, logic [15:0] a);
    return {8'hA0 + 8'(c), 8'h5A, a};
  endfunction

  // internal-port responder: single-cycle ack or err after lat cycles
  always @(posedge clk) begin
    for (int c = 0; c < 2; c++) begin
      if (rst || !ireq[c] || iack[c] || ierr[c]) begin
        iack[c] <= 1'b0;
        ierr[c] <= 1'b0;
        rcnt[c] <= 0;
      end else if (rcnt[c] >= lat[c]) begin
        if (mode[c] == 0) begin
          iack[c]    <= 1'b1;
          last_wa[c] <= iaddr[c*16 +: 16];
          last_wd[c] <= iwdata[c*32 +: 32];
          last_we[c] <= iwe[c];
        end else if (mode[c] == 1) begin
          ierr[c] <= 1'b1;
        end
      end else begin
        rcnt[c] <= rcnt[c] + 1;
      end
    end
  end

  // request monitor
  always @(negedge clk) begin
    for (int c = 0; c < 2; c++) begin
      if (ireq[c]) begin
        if (!prev[c]) rises[c]++;
        cur[c]++;
      end else if (prev[c]) begin
        req_len[c] = cur[c];
        cur[c] = 0;
      end
      prev[c] = ireq[c];
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apb(input logic wr, input logic [7:0] a, input logic [31:0] wd,
                     output logic [31:0] rd, output logic se, output int waits);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = wd;
    @(negedge clk);
    penable = 1'b1;
    waits = 0;
    #1;
    while (!pready) begin
      waits++;
      @(negedge clk);
      #1;
    end
    rd = prdata;
    se = pslverr;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] rd; logic se; int w;
    chk("R12 ireq", {30'd0, ireq}, 32'd0);
    apb(0, 8'h00, 0, rd, se, w); chk("R12 pointer", rd, 32'd0);
    apb(0, 8'h08, 0, rd, se, w); chk("R12 control", rd, 32'd0);
    apb(0, 8'h18, 0, rd, se, w); chk("R12 control B", rd, 32'd0);
  endtask

  task automatic t_pointer;
    logic [31:0] rd; logic se; int w; int r0;
    r0 = rises[0];
    apb(1, 8'h00, 32'h1234_5678, rd, se, w);
    apb(1, 8'h00, 32'h1234_5678, rd, se, w);
    apb(0, 8'h00, 0, rd, se, w);
    chk("R2 pointer low 16 bits", rd, 32'h0000_5678);
    chk("R2 repeat write no request", rises[0] - r0, 0);
    apb(0, 8'h03, 0, rd, se, w);
    chk("R1 low addr bits ignored", rd, 32'h0000_5678);
  endtask

  task automatic t_read;
    logic [31:0] rd; logic se; int w;
    lat[0] = 2; mode[0] = 0;
    apb(1, 8'h00, 32'h0042, rd, se, w);
    apb(1, 8'h00, 32'h0042, rd, se, w);
    apb(0, 8'h04, 0, rd, se, w);
    chk("R3 first read stale", rd, 32'd0);
    chk("R3 first read no wait", w, 0);
    apb(0, 8'h04, 0, rd, se, w);
    chk("R3 second read value", rd, fval(0, 16'h0042));
    chk("R3 fetch was a read", {31'd0, last_we[0]}, 32'd0);
  endtask

  task automatic t_stall;
    logic [31:0] rd; logic se; int w;
    lat[0] = 8; mode[0] = 0;
    apb(1, 8'h00, 32'h0077, rd, se, w);
    apb(0, 8'h04, 0, rd, se, w);
    apb(0, 8'h04, 0, rd, se, w);
    chk("R4 held while fetching", {31'd0, w > 0}, 32'd1);
    chk("R4 value after hold", rd, fval(0, 16'h0077));
  endtask

  task automatic t_write;
    logic [31:0] rd; logic se; int w;
    lat[0] = 3; mode[0] = 0;
    apb(1, 8'h00, 32'h0100, rd, se, w);
    apb(1, 8'h04, 32'hDEAD_BEEF, rd, se, w);
    chk("R5 write held", {31'd0, w >= 4}, 32'd1);
    chk("R5 write address", {16'd0, last_wa[0]}, 32'h0100);
    chk("R5 write data", last_wd[0], 32'hDEAD_BEEF);
    chk("R6 write strobe", {31'd0, last_we[0]}, 32'd1);
    chk("R5 no error", {31'd0, se}, 32'd0);
  endtask

  task automatic t_channels;
    logic [31:0] rd; logic se; int w;
    lat[0] = 1; lat[1] = 1; mode[0] = 0; mode[1] = 0;
    apb(1, 8'h00, 32'h0001, rd, se, w);
    apb(1, 8'h10, 32'h0002, rd, se, w);
    apb(0, 8'h11, 0, rd, se, w);
    chk("R1 channel B pointer", rd, 32'h0002);
    apb(0, 8'h04, 0, rd, se, w);
    apb(0, 8'h14, 0, rd, se, w);
    apb(0, 8'h04, 0, rd, se, w);
    chk("R10 channel A value", rd, fval(0, 16'h0001));
    apb(0, 8'h16, 0, rd, se, w);
    chk("R10 channel B value", rd, fval(1, 16'h0002));
  endtask

  task automatic t_timeout;
    logic [31:0] rd; logic se; int w;
    mode[0] = 2;
    apb(1, 8'h04, 32'h5555_0000, rd, se, w);
    chk("R7 request length", req_len[0], 16);
    chk("R8 no error when disabled", {31'd0, se}, 32'd0);
    apb(1, 8'h08, 32'h0001_8000, rd, se, w);
    apb(0, 8'h08, 0, rd, se, w);
    chk("R8 control readback", rd, 32'h0001_8000);
    apb(1, 8'h04, 32'h5555_0001, rd, se, w);
    chk("R8 write timeout error", {31'd0, se}, 32'd1);
  endtask

  task automatic t_err_read;
    logic [31:0] rd; logic se; int w;
    mode[0] = 1; lat[0] = 1;
    apb(0, 8'h04, 0, rd, se, w);
    apb(0, 8'h04, 0, rd, se, w);
    chk("R9 failed fetch reads zero", rd, 32'd0);
    chk("R8 read error reported", {31'd0, se}, 32'd1);
    apb(1, 8'h08, 32'd0, rd, se, w);
    apb(0, 8'h04, 0, rd, se, w);
    chk("R8 read error masked", {31'd0, se}, 32'd0);
    mode[0] = 0;
  endtask

  task automatic t_undecoded;
    logic [31:0] rd; logic se; int w;
    apb(0, 8'h0C, 0, rd, se, w);
    chk("R11 hole reads zero", rd, 32'd0);
    chk("R11 hole no wait", w, 0);
    apb(1, 8'h20, 32'hFFFF, rd, se, w);
    apb(1, 8'h0C, 32'hFFFF, rd, se, w);
    apb(0, 8'h2C, 0, rd, se, w);
    chk("R11 high channel zero", {rd[31:1], se}, 32'd0);
    apb(0, 8'h00, 0, rd, se, w);
    chk("R11 write had no effect", rd, 32'h0001);
  endtask

  initial begin
    for (int c = 0; c < 2; c++) begin
      lat[c] = 0; mode[c] = 0; rises[c] = 0; cur[c] = 0; req_len[c] = 0;
      prev[c] = 1'b0; last_wa[c] = '0; last_wd[c] = '0; last_we[c] = 1'b0;
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_pointer();
    t_read();
    t_stall();
    t_write();
    t_channels();
    t_timeout();
    t_err_read();
    t_undecoded();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule